// File: doc/BRIEF.md
# Paged Dual-Pair Configuration Register Block

This block holds the configuration of two identical converter datapaths, called pair A (converter channels 0 and 1) and pair B (channels 2 and 3). Every paged register exists twice, once for each pair. Among the paged fields are the interpolation mode and the input-format bit. A host reaches all of them through one small address/data bus, so a single bus address can stand for two physical registers.

A 2-bit page index chooses which copy a paged write reaches. It lives in bits [1:0] of a non-paged register of its own. Index 1 selects pair A and index 2 selects pair B. Index 3 writes both pairs in the same cycle and is the value after reset. Index 0 selects neither pair, and paged writes are then dropped.

Reads of a paged address return one copy. That copy is pair A's for index 1 or 3, and pair B's for index 2. Writes to the page register itself, and to any other non-paged address, do not depend on the current index. The configuration bits of each pair come straight from the register outputs and drive the two datapaths.

Top module: `cfgpg_top`

## Requirements
- R1: After a synchronous reset, every paged register of both pairs holds zero: interpolation bypass and two's-complement format. The page index reads back as 3.
- R2: With page index 1, a write to a paged address loads that register of pair A on the clock edge of the write. Pair B stays unchanged.
- R3: With page index 2, a write to a paged address loads that register of pair B. Pair A stays unchanged.
- R4: With page index 3, a write to a paged address loads the same register in both pairs with the same data.
- R5: With page index 0, writes to paged addresses change neither pair.
- R6: A read strobe loads host_rdata on its clock edge, and host_rdata holds that value until the next strobe. A paged read returns pair A's copy for index 1 or 3, pair B's copy for index 2, and zero for index 0.
- R7: The page register sits at address PAGE_ADDR (default 0x08) and uses bits [1:0]. Reads return the index with all upper bits zero. Writes to it take effect whatever the current index is, and they leave both pairs unchanged.
- R8: Paged register k sits at address PAGED_BASE+k (default 0x10 to 0x13). It appears on pair_x_regs at bits [k*DATA_W +: DATA_W]. The interpolation mode is bits [2:0] of register 0. The format bit is bit 0 of register 1, where 0 means two's complement and 1 means offset binary.
- R9: Writes to unmapped addresses (neither the page register nor a paged address) change nothing, and reads of them return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_addr | input | ADDR_W | Register address |
| host_wdata | input | DATA_W | Write data |
| host_we | input | 1 | Write strobe, one register per cycle |
| host_re | input | 1 | Read strobe |
| host_rdata | output | DATA_W | Registered read data |
| pair_a_interp | output | INTERP_W | Interpolation mode of pair A |
| pair_a_fmt | output | 1 | Input format of pair A (1 = offset binary) |
| pair_a_regs | output | NUM_PAGED*DATA_W | All paged registers of pair A |
| pair_b_interp | output | INTERP_W | Interpolation mode of pair B |
| pair_b_fmt | output | 1 | Input format of pair B (1 = offset binary) |
| pair_b_regs | output | NUM_PAGED*DATA_W | All paged registers of pair B |

## Verification
The bench steps through all four page indices. Under each one it writes every paged register with data that encodes both the index and the register offset, so a write that reached the wrong pair or the wrong offset shows up as a different value. After each step it reads every register back under indices 0, 1, 2 and 3, which separates the A-versus-B read rule from the write fan-out. Extra patterns write the page register while index 0 is active, and write it with upper bits set. Writes to unmapped addresses on both sides of the paged window confirm that the decode bounds are exact.

// File: rtl/cfgpg_pkg.sv
package cfgpg_pkg;
  typedef enum logic [1:0] {
    PG_NONE = 2'd0,
    PG_A    = 2'd1,
    PG_B    = 2'd2,
    PG_BOTH = 2'd3
  } page_e;

  function automatic logic page_hits_a(input page_e p);
    return (p == PG_A) || (p == PG_BOTH);
  endfunction

  function automatic logic page_hits_b(input page_e p);
    return (p == PG_B) || (p == PG_BOTH);
  endfunction
endpackage

// File: rtl/cfgpg_addr_decode.sv
module cfgpg_addr_decode
  import cfgpg_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int NUM_PAGED = 4,
  parameter logic [ADDR_W-1:0] PAGE_ADDR = ADDR_W'(8'h08),
  parameter logic [ADDR_W-1:0] PAGED_BASE = ADDR_W'(8'h10),
  localparam int IDX_W = (NUM_PAGED > 1) ? $clog2(NUM_PAGED) : 1
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              we,
  input  page_e             page,
  output logic              is_page,
  output logic              is_paged,
  output logic [IDX_W-1:0]  idx,
  output logic              page_wr,
  output logic              wr_a,
  output logic              wr_b
);
  localparam logic [ADDR_W-1:0] NP = ADDR_W'(NUM_PAGED);
  logic [ADDR_W-1:0] offset;

  always_comb begin
    offset   = addr - PAGED_BASE;
    is_page  = (addr == PAGE_ADDR);
    is_paged = (addr >= PAGED_BASE) && (offset < NP);
    idx      = offset[IDX_W-1:0];
    page_wr  = we && is_page;
    wr_a     = we && is_paged && page_hits_a(page);
    wr_b     = we && is_paged && page_hits_b(page);
  end
endmodule

// File: rtl/cfgpg_pair_bank.sv
module cfgpg_pair_bank #(
  parameter int DATA_W = 8,
  parameter int NUM_PAGED = 4,
  localparam int IDX_W = (NUM_PAGED > 1) ? $clog2(NUM_PAGED) : 1
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        wr_en,
  input  logic [IDX_W-1:0]            wr_idx,
  input  logic [DATA_W-1:0]           wr_data,
  output logic [NUM_PAGED*DATA_W-1:0] regs_flat
);
  logic [DATA_W-1:0] mem [NUM_PAGED];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_PAGED; i++) mem[i] <= '0;
    end else if (wr_en) begin
      mem[wr_idx] <= wr_data;
    end
  end

  for (genvar g = 0; g < NUM_PAGED; g++) begin : g_flat
    assign regs_flat[g*DATA_W +: DATA_W] = mem[g];
  end
endmodule

// File: rtl/cfgpg_readback.sv
module cfgpg_readback
  import cfgpg_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int NUM_PAGED = 4,
  localparam int IDX_W = (NUM_PAGED > 1) ? $clog2(NUM_PAGED) : 1
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        re,
  input  logic                        is_page,
  input  logic                        is_paged,
  input  logic [IDX_W-1:0]            idx,
  input  page_e                       page,
  input  logic [NUM_PAGED*DATA_W-1:0] a_flat,
  input  logic [NUM_PAGED*DATA_W-1:0] b_flat,
  output logic [DATA_W-1:0]           rdata
);
  logic [DATA_W-1:0] sel;

  always_comb begin
    sel = '0;
    if (is_page) begin
      sel = DATA_W'(page);
    end else if (is_paged) begin
      unique case (page)
        PG_A, PG_BOTH: sel = a_flat[idx*DATA_W +: DATA_W];
        PG_B:          sel = b_flat[idx*DATA_W +: DATA_W];
        default:       sel = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst)     rdata <= '0;
    else if (re) rdata <= sel;
  end
endmodule

// File: rtl/cfgpg_top.sv
module cfgpg_top
  import cfgpg_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter int NUM_PAGED = 4,
  parameter int INTERP_W = 3,
  parameter logic [ADDR_W-1:0] PAGE_ADDR = ADDR_W'(8'h08),
  parameter logic [ADDR_W-1:0] PAGED_BASE = ADDR_W'(8'h10)
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [ADDR_W-1:0]           host_addr,
  input  logic [DATA_W-1:0]           host_wdata,
  input  logic                        host_we,
  input  logic                        host_re,
  output logic [DATA_W-1:0]           host_rdata,
  output logic [INTERP_W-1:0]         pair_a_interp,
  output logic                        pair_a_fmt,
  output logic [NUM_PAGED*DATA_W-1:0] pair_a_regs,
  output logic [INTERP_W-1:0]         pair_b_interp,
  output logic                        pair_b_fmt,
  output logic [NUM_PAGED*DATA_W-1:0] pair_b_regs
);
  localparam int IDX_W = (NUM_PAGED > 1) ? $clog2(NUM_PAGED) : 1;
  localparam int INTERP_REG = 0;
  localparam int FMT_REG = 1;
  localparam int FMT_BIT = 0;
  localparam int NPAIR = 2;

  page_e             page_q;
  logic              is_page, is_paged, page_wr;
  logic [IDX_W-1:0]  idx;
  logic [NPAIR-1:0]  wr_pair;
  logic [NUM_PAGED*DATA_W-1:0] flat [NPAIR];

  cfgpg_addr_decode #(
    .ADDR_W(ADDR_W), .NUM_PAGED(NUM_PAGED),
    .PAGE_ADDR(PAGE_ADDR), .PAGED_BASE(PAGED_BASE)
  ) u_dec (
    .addr(host_addr), .we(host_we), .page(page_q),
    .is_page(is_page), .is_paged(is_paged), .idx(idx),
    .page_wr(page_wr), .wr_a(wr_pair[0]), .wr_b(wr_pair[1])
  );

  always_ff @(posedge clk) begin
    if (rst)          page_q <= PG_BOTH;
    else if (page_wr) page_q <= page_e'(host_wdata[1:0]);
  end

  for (genvar p = 0; p < NPAIR; p++) begin : g_pair
    cfgpg_pair_bank #(.DATA_W(DATA_W), .NUM_PAGED(NUM_PAGED)) u_bank (
      .clk(clk), .rst(rst), .wr_en(wr_pair[p]), .wr_idx(idx),
      .wr_data(host_wdata), .regs_flat(flat[p])
    );
  end

  cfgpg_readback #(.DATA_W(DATA_W), .NUM_PAGED(NUM_PAGED)) u_rb (
    .clk(clk), .rst(rst), .re(host_re), .is_page(is_page),
    .is_paged(is_paged), .idx(idx), .page(page_q),
    .a_flat(flat[0]), .b_flat(flat[1]), .rdata(host_rdata)
  );

  assign pair_a_regs   = flat[0];
  assign pair_b_regs   = flat[1];
  assign pair_a_interp = flat[0][INTERP_REG*DATA_W +: INTERP_W];
  assign pair_b_interp = flat[1][INTERP_REG*DATA_W +: INTERP_W];
  assign pair_a_fmt    = flat[0][FMT_REG*DATA_W + FMT_BIT];
  assign pair_b_fmt    = flat[1][FMT_REG*DATA_W + FMT_BIT];
endmodule

// File: rtl/cfgpg_chk.sv
module cfgpg_chk #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter int NUM_PAGED = 4,
  parameter logic [ADDR_W-1:0] PAGE_ADDR = ADDR_W'(8'h08),
  parameter logic [ADDR_W-1:0] PAGED_BASE = ADDR_W'(8'h10)
) (
  input logic                        clk,
  input logic                        rst,
  input logic [ADDR_W-1:0]           host_addr,
  input logic [DATA_W-1:0]           host_wdata,
  input logic                        host_we,
  input logic [1:0]                  page_q,
  input logic [NUM_PAGED*DATA_W-1:0] a_flat,
  input logic [NUM_PAGED*DATA_W-1:0] b_flat
);
  localparam int IDX_W = (NUM_PAGED > 1) ? $clog2(NUM_PAGED) : 1;
  localparam logic [ADDR_W-1:0] NP = ADDR_W'(NUM_PAGED);
  logic [ADDR_W-1:0] off;
  logic              in_win;
  logic [IDX_W-1:0]  idx_q;

  assign off    = host_addr - PAGED_BASE;
  assign in_win = (host_addr >= PAGED_BASE) && (off < NP);

  always_ff @(posedge clk) idx_q <= off[IDX_W-1:0];

  // R1
  reset_zero_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (a_flat == '0) && (b_flat == '0) && (page_q == 2'd3));

  // R2
  page_a_only_chk: assert property (@(posedge clk) disable iff (rst)
    (host_we && in_win && page_q == 2'd1) |=>
      (a_flat[idx_q*DATA_W +: DATA_W] == $past(host_wdata)) && $stable(b_flat));

  // R3
  page_b_only_chk: assert property (@(posedge clk) disable iff (rst)
    (host_we && in_win && page_q == 2'd2) |=>
      (b_flat[idx_q*DATA_W +: DATA_W] == $past(host_wdata)) && $stable(a_flat));

  // R4
  page_both_chk: assert property (@(posedge clk) disable iff (rst)
    (host_we && in_win && page_q == 2'd3) |=>
      (a_flat[idx_q*DATA_W +: DATA_W] == $past(host_wdata)) &&
      (b_flat[idx_q*DATA_W +: DATA_W] == $past(host_wdata)));

  // R5
  page_none_chk: assert property (@(posedge clk) disable iff (rst)
    (host_we && in_win && page_q == 2'd0) |=> $stable(a_flat) && $stable(b_flat));

  // R7
  page_reg_wr_chk: assert property (@(posedge clk) disable iff (rst)
    (host_we && host_addr == PAGE_ADDR) |=>
      (page_q == $past(host_wdata[1:0])) && $stable(a_flat) && $stable(b_flat));

  // R9
  unmapped_wr_chk: assert property (@(posedge clk) disable iff (rst)
    (host_we && !in_win && host_addr != PAGE_ADDR) |=>
      $stable(a_flat) && $stable(b_flat) && $stable(page_q));
endmodule

bind cfgpg_top cfgpg_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_PAGED(NUM_PAGED),
  .PAGE_ADDR(PAGE_ADDR), .PAGED_BASE(PAGED_BASE)
) u_chk (
  .clk(clk), .rst(rst), .host_addr(host_addr), .host_wdata(host_wdata),
  .host_we(host_we), .page_q(page_q), .a_flat(flat[0]), .b_flat(flat[1])
);

// File: tb/cfgpg_top_tb.sv
`timescale 1ns/1ps
module cfgpg_top_tb;
  localparam int NP = 4;
  localparam int DW = 8;
  localparam logic [7:0] PADDR = 8'h08;
  localparam logic [7:0] BASE = 8'h10;

  logic clk = 0, rst = 1;
  logic [7:0] host_addr = '0, host_wdata = '0, host_rdata;
  logic host_we = 0, host_re = 0;
  logic [2:0] a_interp, b_interp;
  logic a_fmt, b_fmt;
  logic [NP*DW-1:0] a_regs, b_regs;

  int checks = 0, fails = 0;
  logic [7:0] ma [NP];
  logic [7:0] mb [NP];
  logic [1:0] mpage;

  always #10 clk = ~clk;

  cfgpg_top u_dut (
    .clk(clk), .rst(rst), .host_addr(host_addr), .host_wdata(host_wdata),
    .host_we(host_we), .host_re(host_re), .host_rdata(host_rdata),
    .pair_a_interp(a_interp), .pair_a_fmt(a_fmt), .pair_a_regs(a_regs),
    .pair_b_interp(b_interp), .pair_b_fmt(b_fmt), .pair_b_regs(b_regs)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    host_addr = a; host_wdata = d; host_we = 1;
    @(negedge clk);
    host_we = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    host_addr = a; host_re = 1;
    @(negedge clk);
    host_re = 0;
    d = host_rdata;
  endtask

  function automatic logic [31:0] flat_of(input logic [7:0] m [NP]);
    logic [31:0] f;
    for (int k = 0; k < NP; k++) f[k*8 +: 8] = m[k];
    return f;
  endfunction

  function automatic logic [7:0] exp_read(input logic [1:0] p, input int k);
    if (p == 2'd0) return 8'h00;
    if (p == 2'd2) return mb[k];
    return ma[k];
  endfunction

  task automatic sweep_reads(input string tag);
    logic [7:0] d;
    for (int p = 0; p < 4; p++) begin
      wr(PADDR, 8'(p));
      for (int k = 0; k < NP; k++) begin
        rd(BASE + 8'(k), d);
        chk(tag, {24'h0, d}, {24'h0, exp_read(2'(p), k)});
      end
    end
    wr(PADDR, {6'h0, mpage});
  endtask

  initial begin
    #(200000 * 20);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] d;
    for (int k = 0; k < NP; k++) begin ma[k] = 0; mb[k] = 0; end
    mpage = 2'd3;
    repeat (3) @(negedge clk);
    rst = 0;

    // R1 reset state
    chk("R1 pair A regs", a_regs, 32'h0);
    chk("R1 pair B regs", b_regs, 32'h0);
    chk("R1 interp/fmt", {26'h0, a_interp, a_fmt, b_interp, b_fmt}, 32'h0);
    rd(PADDR, d);
    chk("R1 page index", {24'h0, d}, 32'h3);

    // R2..R5 write fan-out under each index
    for (int p = 0; p < 4; p++) begin
      wr(PADDR, 8'(p));
      mpage = 2'(p);
      rd(PADDR, d);
      chk("R7 page readback", {24'h0, d}, p);
      for (int k = 0; k < NP; k++) begin
        logic [7:0] v;
        v = 8'((p << 6) | ((k + 1) * 8'h0b) | 8'h01);
        wr(BASE + 8'(k), v);
        if (p == 1 || p == 3) ma[k] = v;
        if (p == 2 || p == 3) mb[k] = v;
      end
      case (p)
        0: begin chk("R5 pair A", a_regs, flat_of(ma)); chk("R5 pair B", b_regs, flat_of(mb)); end
        1: begin chk("R2 pair A", a_regs, flat_of(ma)); chk("R2 pair B", b_regs, flat_of(mb)); end
        2: begin chk("R3 pair A", a_regs, flat_of(ma)); chk("R3 pair B", b_regs, flat_of(mb)); end
        default: begin chk("R4 pair A", a_regs, flat_of(ma)); chk("R4 pair B", b_regs, flat_of(mb)); end
      endcase
      sweep_reads("R6 paged readback");
    end

    // make pairs differ, then R8 field taps
    wr(PADDR, 8'h01); wr(BASE, 8'hFA); wr(BASE + 8'd1, 8'h7E);
    ma[0] = 8'hFA; ma[1] = 8'h7E;
    wr(PADDR, 8'h02); wr(BASE, 8'h03); wr(BASE + 8'd1, 8'h81);
    mb[0] = 8'h03; mb[1] = 8'h81; mpage = 2'd2;
    chk("R8 A interp", {29'h0, a_interp}, {29'h0, ma[0][2:0]});
    chk("R8 A fmt", {31'h0, a_fmt}, {31'h0, ma[1][0]});
    chk("R8 B interp", {29'h0, b_interp}, {29'h0, mb[0][2:0]});
    chk("R8 B fmt", {31'h0, b_fmt}, {31'h0, mb[1][0]});
    sweep_reads("R6 distinct pairs");

    // R6 read data holds between strobes
    rd(BASE, d);
    @(negedge clk); host_addr = BASE + 8'd1;
    @(negedge clk);
    chk("R6 rdata hold", {24'h0, host_rdata}, {24'h0, mb[0]});

    // R7 upper bits ignored, page write while index 0
    wr(PADDR, 8'h00); wr(PADDR, 8'hFE);
    rd(PADDR, d);
    chk("R7 upper bits", {24'h0, d}, 32'h2);
    chk("R7 regs untouched", b_regs, flat_of(mb));

    // R9 unmapped addresses on both sides of the window
    wr(PADDR, 8'h03); mpage = 2'd3;
    wr(BASE - 8'd1, 8'hFF); wr(BASE + 8'(NP), 8'hFF); wr(8'h00, 8'hFF);
    chk("R9 A untouched", a_regs, flat_of(ma));
    chk("R9 B untouched", b_regs, flat_of(mb));
    rd(BASE + 8'(NP), d);
    chk("R9 unmapped read", {24'h0, d}, 32'h0);
    rd(PADDR, d);
    chk("R9 page untouched", {24'h0, d}, 32'h3);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule